// File: doc/BRIEF.md
# Global History Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a shift register with the taken or not-taken results of the most recent branches, whatever their address. It combines that history with a slice of the fetch address to pick one entry in a table of two-bit saturating counters. The upper bit of the chosen counter is the prediction. The hash is an exclusive-or of the history and the address slice. Because the history takes part in the index, a branch whose direction depends on the path taken through earlier branches can use a different counter for each path.

The fetch side is purely combinational. The fetch address goes in, and the taken flag comes out in the same cycle. The resolve side reports the real outcome of a branch, together with its address. On the next rising edge two things happen. First, the counter at the address-and-history index is stepped toward the outcome. Second, the outcome enters the history at bit 0.

Resolves are expected in program order, each one before any later branch is predicted. So the history seen at resolve time is the same history that the prediction used. The block never back-pressures: there is no ready signal, a resolve is taken on every cycle that `resolve_valid` is high, and no handshake is needed. History repair after a flush and target prediction are handled elsewhere.

Top module: `gshare_dir_pred`

## Requirements
- R1: After reset, every table entry holds weakly taken (binary 10), so every fetch address predicts taken (`pred_taken`=1) until it is trained.
- R2: The table index is `history[7:0] XOR pc[9:2]`. The same index is used for the fetch lookup (with `fetch_pc`) and for training (with `resolve_pc`), both against the current history.
- R3: A counter at 11 (strongly taken) stays at 11 when trained taken.
- R4: A counter at 00 (strongly not taken) stays at 00 when trained not taken.
- R5: Otherwise a counter moves up by one on a taken resolve and down by one on a not-taken resolve. So from a strong state, two opposite outcomes in a row are needed before `pred_taken` flips.
- R6: Each accepted resolve shifts the history left by one and places the outcome in bit 0 (1 = taken). The oldest bit is dropped.
- R7: The history resets to all zeros.
- R8: In a cycle with `resolve_valid` low, neither the history nor any counter changes. With a steady `fetch_pc`, the prediction then stays the same.
- R9: `pred_taken` follows `fetch_pc` in the same cycle. A resolve changes the prediction only from the following clock edge on.
- R10: Address bits outside `pc[9:2]` have no effect on the prediction or on which entry is trained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | 32 | Address being fetched |
| pred_taken | output | 1 | Predicted direction for `fetch_pc` (1 = taken) |
| resolve_valid | input | 1 | A branch outcome is presented this cycle; always accepted |
| resolve_pc | input | 32 | Address of the resolved branch |
| resolve_taken | input | 1 | Actual outcome of the resolved branch (1 = taken) |

## Verification
The properties assume two things about the inputs. First, `resolve_pc` and `resolve_taken` are known whenever `resolve_valid` is high. Second, the fetch and resolve inputs change only between clock edges, so a counter step or a history shift can be checked one cycle after the resolve that caused it. The stimulus drives every input on the falling edge and holds it for a full cycle. It sends resolves in program order. It picks training addresses by folding the model's current history into `pc[9:2]`, so that one counter can be driven on purpose into each saturation limit and back across the prediction threshold.

// File: rtl/gshare_pkg.sv
package gshare_pkg;

  typedef logic [1:0] sat2_t;

  localparam sat2_t SAT_STRONG_NT = 2'b00;
  localparam sat2_t SAT_WEAK_NT   = 2'b01;
  localparam sat2_t SAT_WEAK_T    = 2'b10;
  localparam sat2_t SAT_STRONG_T  = 2'b11;

  // Saturating step toward the observed outcome.
  function automatic sat2_t sat2_step(input sat2_t cur, input logic taken);
    sat2_t nxt;
    if (taken) nxt = (cur == SAT_STRONG_T)  ? cur : sat2_t'(cur + 2'd1);
    else       nxt = (cur == SAT_STRONG_NT) ? cur : sat2_t'(cur - 2'd1);
    return nxt;
  endfunction

endpackage

// File: rtl/gshare_hist.sv
module gshare_hist #(
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          bit_in,
  output logic [HW-1:0] hist
);
  logic [HW-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        hist_q <= '0;
    else if (shift_en) hist_q <= {hist_q[HW-2:0], bit_in};
  end

  assign hist = hist_q;
endmodule

// File: rtl/gshare_hash.sv
module gshare_hash #(
  parameter int HW = 8
) (
  input  logic [HW-1:0] pc_slice,
  input  logic [HW-1:0] hist,
  output logic [HW-1:0] idx
);
  assign idx = pc_slice ^ hist;
endmodule

// File: rtl/gshare_pht.sv
module gshare_pht
  import gshare_pkg::*;
#(
  parameter int IW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IW-1:0]       wr_idx,
  input  logic                wr_taken,
  output logic [2*(1<<IW)-1:0] flat
);
  localparam int ENTRIES = 1 << IW;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    sat2_t ctr_q;
    logic  hit;
    assign hit = wr_en && (wr_idx == IW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)   ctr_q <= SAT_WEAK_T;
      else if (hit) ctr_q <= sat2_step(ctr_q, wr_taken);
    end
    assign flat[2*g +: 2] = ctr_q;
  end
endmodule

// File: rtl/gshare_dir_pred.sv
module gshare_dir_pred #(
  parameter int PC_W   = 32,
  parameter int PC_LSB = 2,
  parameter int HW     = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_taken,
  input  logic            resolve_valid,
  input  logic [PC_W-1:0] resolve_pc,
  input  logic            resolve_taken
);
  localparam int ENTRIES = 1 << HW;
  localparam int FLAT_W  = 2 * ENTRIES;

  logic [HW-1:0]     ghist_q;
  logic [HW-1:0]     fetch_idx;
  logic [HW-1:0]     upd_idx;
  logic [FLAT_W-1:0] pht_flat;
  logic              unused_pc_bits;

  assign unused_pc_bits = ^{fetch_pc, resolve_pc};

  gshare_hist #(.HW(HW)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (resolve_valid),
    .bit_in   (resolve_taken),
    .hist     (ghist_q)
  );

  gshare_hash #(.HW(HW)) u_hash_fetch (
    .pc_slice (fetch_pc[PC_LSB +: HW]),
    .hist     (ghist_q),
    .idx      (fetch_idx)
  );

  gshare_hash #(.HW(HW)) u_hash_upd (
    .pc_slice (resolve_pc[PC_LSB +: HW]),
    .hist     (ghist_q),
    .idx      (upd_idx)
  );

  gshare_pht #(.IW(HW)) u_pht (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (resolve_valid),
    .wr_idx   (upd_idx),
    .wr_taken (resolve_taken),
    .flat     (pht_flat)
  );

  assign pred_taken = pht_flat[{fetch_idx, 1'b1}];
endmodule

// File: rtl/gshare_chk.sv
module gshare_chk #(
  parameter int PC_W   = 32,
  parameter int PC_LSB = 2,
  parameter int HW     = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [PC_W-1:0]       fetch_pc,
  input logic                  pred_taken,
  input logic                  resolve_valid,
  input logic [PC_W-1:0]       resolve_pc,
  input logic                  resolve_taken,
  input logic [HW-1:0]         ghist,
  input logic [2*(1<<HW)-1:0]  table_flat
);
  logic [HW-1:0] cur_idx, cap_idx;
  logic [1:0]    cur_old, cap_old, cap_now;

  assign cur_idx = resolve_pc[PC_LSB +: HW] ^ ghist;
  assign cur_old = table_flat[{cur_idx, 1'b0} +: 2];
  assign cap_now = table_flat[{cap_idx, 1'b0} +: 2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_idx <= '0;
      cap_old <= 2'b10;
    end else if (resolve_valid) begin
      cap_idx <= cur_idx;
      cap_old <= cur_old;
    end
  end

  // R6
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resolve_valid |=> ghist == {$past(ghist[HW-2:0]), $past(resolve_taken)});

  // R8
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !resolve_valid |=> $stable(ghist));

  // R8
  pred_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !resolve_valid |=> (!$stable(fetch_pc) || $stable(pred_taken)));

  // R3
  sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resolve_valid && resolve_taken && cur_old == 2'b11) |=> cap_now == 2'b11);

  // R4
  sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resolve_valid && !resolve_taken && cur_old == 2'b00) |=> cap_now == 2'b00);

  // R5
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resolve_valid && resolve_taken && cur_old != 2'b11) |=> cap_now == 2'(cap_old + 2'd1));

  // R5
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resolve_valid && !resolve_taken && cur_old != 2'b00) |=> cap_now == 2'(cap_old - 2'd1));
endmodule

bind gshare_dir_pred gshare_chk #(.PC_W(PC_W), .PC_LSB(PC_LSB), .HW(HW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .fetch_pc      (fetch_pc),
  .pred_taken    (pred_taken),
  .resolve_valid (resolve_valid),
  .resolve_pc    (resolve_pc),
  .resolve_taken (resolve_taken),
  .ghist         (ghist_q),
  .table_flat    (pht_flat)
);

// File: tb/sim_gshare_dir_pred.sv
module sim_gshare_dir_pred;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        pred_taken;
  logic        resolve_valid = 1'b0;
  logic [31:0] resolve_pc = '0;
  logic        resolve_taken = 1'b0;

  always #2 clk = ~clk;

  gshare_dir_pred u0 (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_taken(pred_taken),
    .resolve_valid(resolve_valid), .resolve_pc(resolve_pc), .resolve_taken(resolve_taken)
  );

  typedef struct { logic exp; string tag; } item_t;
  item_t q[$];

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [1:0] m_pht [256];
  logic [7:0] m_ghr;

  function automatic logic [31:0] pc_for(input logic [7:0] idx, input logic [21:0] hi);
    return {hi, idx ^ m_ghr, 2'b00};
  endfunction

  task automatic step(input logic [31:0] fpc, input logic rv, input logic [31:0] rpc,
                      input logic ro, input string tag);
    item_t it;
    logic [7:0] ui;
    @(negedge clk);
    fetch_pc = fpc;
    resolve_valid = rv;
    resolve_pc = rpc;
    resolve_taken = ro;
    it.exp = m_pht[fpc[9:2] ^ m_ghr][1];
    it.tag = tag;
    q.push_back(it);
    if (rv) begin
      ui = rpc[9:2] ^ m_ghr;
      if (ro) m_pht[ui] = (m_pht[ui] == 2'b11) ? 2'b11 : m_pht[ui] + 2'd1;
      else    m_pht[ui] = (m_pht[ui] == 2'b00) ? 2'b00 : m_pht[ui] - 2'd1;
      m_ghr = {m_ghr[6:0], ro};
    end
  endtask

  // train entry idx and look it up in the same cycle
  task automatic train(input logic [7:0] idx, input logic ro, input string tag);
    logic [31:0] p;
    p = pc_for(idx, 22'h2a);
    step(p, 1'b1, p, ro, tag);
  endtask

  task automatic look(input logic [7:0] idx, input logic [21:0] hi, input string tag);
    step(pc_for(idx, hi), 1'b0, 32'h0, 1'b0, tag);
  endtask

  // monitor: compare just after the falling edge
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        it = q.pop_front();
        total++;
        if (pred_taken !== it.exp) begin
          bad++;
          $display("FAIL %s: pred_taken actual=%0b expected=%0b", it.tag, pred_taken, it.exp);
        end
      end
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    for (int i = 0; i < 256; i++) m_pht[i] = 2'b10;
    m_ghr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: untrained entries predict taken
    for (int i = 0; i < 6; i++) look(8'(i * 37), 22'(i), "R1");

    // R7 / R2: history zero, so training pc slice 0x14 hits entry 0x14
    step(32'h0000_0050, 1'b1, 32'h0000_0050, 1'b0, "R9");
    step(32'h0000_0050, 1'b0, 32'h0, 1'b0, "R7");
    // R10: upper bits ignored
    step(32'hfff0_0050, 1'b0, 32'h0, 1'b0, "R10");
    // R6: taken resolve makes history 0x01; pc slice 0x15 then maps to 0x14
    step(32'h0000_0400, 1'b1, 32'h0000_0400, 1'b1, "R6");
    step(32'h0000_0054, 1'b0, 32'h0, 1'b0, "R6");
    step(32'h0000_0050, 1'b0, 32'h0, 1'b0, "R2");

    // R3 and R5: saturate high, then two misses flip
    for (int i = 0; i < 4; i++) train(8'h33, 1'b1, "R3");
    look(8'h33, 22'h1, "R3");
    train(8'h33, 1'b0, "R5");
    look(8'h33, 22'h2, "R5");
    train(8'h33, 1'b0, "R5");
    look(8'h33, 22'h3, "R5");

    // R4 and R5: saturate low, then two hits flip back
    for (int i = 0; i < 4; i++) train(8'h7c, 1'b0, "R4");
    look(8'h7c, 22'h4, "R4");
    train(8'h7c, 1'b1, "R5");
    look(8'h7c, 22'h5, "R5");
    train(8'h7c, 1'b1, "R5");
    look(8'h7c, 22'h6, "R5");

    // R8: idle cycles hold prediction
    for (int i = 0; i < 5; i++) look(8'h33, 22'h7, "R8");

    // mixed traffic against the model
    lf = 16'hace1;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step({lf, lf}, lf[0], {lf[7:0], lf[15:0], lf[15:8]}, lf[3] ^ lf[9], "R2");
    end

    @(negedge clk);
    #2;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule